// File: doc/BRIEF.md
# Character Dot-Row Fetch Unit

This block turns a character code and a dot-row index into the 5-dot slice that the segment drivers show for that row. Codes 00h to 03h select one of four user-editable glyphs held in an internal 32-entry by 5-bit pattern RAM. Every other code is passed to an external fixed-glyph store through a request port, and that store answers one clock later. A request can instead be marked as an icon row. In that case the row index picks one of eight 5-bit entries of an internal icon RAM, and the character code plays no part.

Requests enter through a valid/ready stream. Finished rows leave through a second valid/ready stream. One output register sits between the two streams. A request is accepted when `req_valid` is high and `req_ready` is high. `req_ready` is high when the output register is empty or is being drained in the same cycle. While `pat_valid` is high and `pat_ready` is low, the output holds its value, even if the fixed store's answer moves on. A separate plain write port lets the processor load either RAM by address at any time, with no back-pressure.

Top module: `glyph_row_fetch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pat_valid` is 0 and `req_ready` is 1.
- R2: An accepted character request with a code in 0..3 produces `pat_data` equal to pattern RAM entry `code*8 + row`.
- R3: An accepted character request with a code of 4 or above raises `rom_req_valid` in the same cycle, with `rom_code` and `rom_row` equal to the request. The `pat_data` then delivered equals the value on `rom_data` one clock later. No other cycle raises `rom_req_valid`.
- R4: `pat_valid` rises in the cycle after an accepted request, whichever source serves it.
- R5: An accepted request with `req_icon` = 1 delivers icon RAM entry `row`. The character code is ignored and no external request is issued.
- R6: A write with `wr_en` = 1 stores `wr_data`. With `wr_icon` = 0 it goes to pattern entry `wr_addr[4:0]`. With `wr_icon` = 1 it goes to icon entry `wr_addr[2:0]`, and the upper address bits are ignored.
- R7: If a write and an accepted request address the same entry on the same edge, the request receives the old contents. The new data appears on the next read.
- R8: `req_ready` equals `!pat_valid || pat_ready`. While `pat_valid` is 1 and `pat_ready` is 0, `pat_valid` and `pat_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_icon | input | 1 | Request is an icon row |
| req_code | input | 8 | Character code |
| req_row | input | 3 | Dot row 0..7 |
| pat_valid | output | 1 | Output row present |
| pat_ready | input | 1 | Consumer takes output row |
| pat_data | output | 5 | Dot pattern of the row |
| rom_req_valid | output | 1 | Fixed-store lookup strobe |
| rom_code | output | 8 | Code to the fixed store |
| rom_row | output | 3 | Row to the fixed store |
| rom_data | input | 5 | Fixed-store answer, one clock after the strobe |
| wr_en | input | 1 | Processor write strobe |
| wr_icon | input | 1 | 1 selects the icon RAM, 0 the pattern RAM |
| wr_addr | input | 5 | Write address |
| wr_data | input | 5 | Write data |

## Verification
Two things can happen on the same clock edge: a processor write, and an accepted read of the entry that write targets. The bench provokes this in a dedicated phase. In that phase, each request is paired with a write aimed at the exact pattern or icon entry the request reads. The reference model computes the expected row from its memory image before it applies that edge's write. A design that forwards the new data is therefore flagged under R7. The phase also issues a later read of the same entry, which confirms that the new data has landed.

// File: rtl/glyph_fetch_pkg.sv
package glyph_fetch_pkg;
  typedef enum logic [1:0] {
    SRC_USER  = 2'd0,
    SRC_FIXED = 2'd1,
    SRC_ICON  = 2'd2
  } glyph_src_e;
endpackage

// File: rtl/glyph_dot_ram.sv
module glyph_dot_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 5,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  // Write path: no reset on the array.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read. When a write and a read hit the same entry on one edge,
  // the read returns the old contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rq <= '0;
    else if (re) rq <= mem[raddr];
  end
endmodule

// File: rtl/glyph_route.sv
module glyph_route
  import glyph_fetch_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int ROW_W      = 3,
  parameter int USER_CHARS = 4,
  localparam int UC_AW     = $clog2(USER_CHARS),
  localparam int PAT_AW    = UC_AW + ROW_W
) (
  input  logic              fire,
  input  logic              icon,
  input  logic [CODE_W-1:0] code,
  input  logic [ROW_W-1:0]  row,
  output glyph_src_e        src,
  output logic [PAT_AW-1:0] pat_addr,
  output logic              user_re,
  output logic              icon_re,
  output logic              fixed_req
);
  logic is_user;

  always_comb begin
    is_user   = (code < CODE_W'(USER_CHARS));
    pat_addr  = {code[UC_AW-1:0], row};
    if (icon)         src = SRC_ICON;
    else if (is_user) src = SRC_USER;
    else              src = SRC_FIXED;
    user_re   = fire && (src == SRC_USER);
    icon_re   = fire && (src == SRC_ICON);
    fixed_req = fire && (src == SRC_FIXED);
  end
endmodule

// File: rtl/glyph_out_stage.sv
module glyph_out_stage
  import glyph_fetch_pkg::*;
#(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  glyph_src_e    src,
  input  logic [DW-1:0] user_q,
  input  logic [DW-1:0] icon_q,
  input  logic [DW-1:0] rom_data,
  output logic          pat_valid,
  input  logic          pat_ready,
  output logic [DW-1:0] pat_data
);
  glyph_src_e    src_q;
  logic          held;
  logic [DW-1:0] hold_q;
  logic          fire;

  assign req_ready = !pat_valid || pat_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_valid <= 1'b0;
      src_q     <= SRC_USER;
      held      <= 1'b0;
      hold_q    <= '0;
    end else if (fire) begin
      pat_valid <= 1'b1;
      src_q     <= src;
      held      <= 1'b0;
    end else if (pat_valid && pat_ready) begin
      pat_valid <= 1'b0;
      held      <= 1'b0;
    end else if (pat_valid && !held) begin
      // Stalled: capture the one-shot fixed-store answer.
      held      <= 1'b1;
      hold_q    <= pat_data;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_ICON:  pat_data = icon_q;
      SRC_FIXED: pat_data = held ? hold_q : rom_data;
      default:   pat_data = user_q;
    endcase
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !pat_valid);
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> pat_valid);
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && !pat_ready) |=> (pat_valid && $stable(pat_data)));
endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
  import glyph_fetch_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int ROW_W      = 3,
  parameter int DOT_W      = 5,
  parameter int USER_CHARS = 4,
  parameter int ICON_ROWS  = 8,
  localparam int PAT_AW    = $clog2(USER_CHARS) + ROW_W,
  localparam int ICON_AW   = $clog2(ICON_ROWS),
  localparam int WR_AW     = (PAT_AW > ICON_AW) ? PAT_AW : ICON_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_icon,
  input  logic [CODE_W-1:0] req_code,
  input  logic [ROW_W-1:0]  req_row,
  output logic              pat_valid,
  input  logic              pat_ready,
  output logic [DOT_W-1:0]  pat_data,
  output logic              rom_req_valid,
  output logic [CODE_W-1:0] rom_code,
  output logic [ROW_W-1:0]  rom_row,
  input  logic [DOT_W-1:0]  rom_data,
  input  logic              wr_en,
  input  logic              wr_icon,
  input  logic [WR_AW-1:0]  wr_addr,
  input  logic [DOT_W-1:0]  wr_data
);
  localparam int PAT_DEPTH = USER_CHARS << ROW_W;

  glyph_src_e        src;
  logic [PAT_AW-1:0] pat_addr;
  logic              user_re, icon_re;
  logic [DOT_W-1:0]  user_q, icon_q;
  logic              fire;

  assign fire     = req_valid && req_ready;
  assign rom_code = req_code;
  assign rom_row  = req_row;

  glyph_route #(.CODE_W(CODE_W), .ROW_W(ROW_W), .USER_CHARS(USER_CHARS)) u_route (
    .fire(fire), .icon(req_icon), .code(req_code), .row(req_row),
    .src(src), .pat_addr(pat_addr), .user_re(user_re), .icon_re(icon_re),
    .fixed_req(rom_req_valid)
  );

  glyph_dot_ram #(.DEPTH(PAT_DEPTH), .DW(DOT_W)) u_user_ram (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en && !wr_icon), .waddr(wr_addr[PAT_AW-1:0]), .wdata(wr_data),
    .re(user_re), .raddr(pat_addr), .rq(user_q)
  );

  glyph_dot_ram #(.DEPTH(ICON_ROWS), .DW(DOT_W)) u_icon_ram (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en && wr_icon), .waddr(wr_addr[ICON_AW-1:0]), .wdata(wr_data),
    .re(icon_re), .raddr(req_row[ICON_AW-1:0]), .rq(icon_q)
  );

  glyph_out_stage #(.DW(DOT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .src(src), .user_q(user_q), .icon_q(icon_q), .rom_data(rom_data),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_data(pat_data)
  );

  p_rom_only_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_valid |-> (req_valid && req_ready && !req_icon &&
                       req_code >= CODE_W'(USER_CHARS)));
  p_icon_no_rom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_icon) |-> !rom_req_valid);
endmodule

// File: tb/tb_glyph_row_fetch.sv
module tb_glyph_row_fetch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       req_valid = 0, req_icon = 0, pat_ready = 0;
  logic [7:0] req_code = 0;
  logic [2:0] req_row = 0;
  logic       wr_en = 0, wr_icon = 0;
  logic [4:0] wr_addr = 0, wr_data = 0;
  logic       req_ready, pat_valid, rom_req_valid;
  logic [4:0] pat_data, rom_data;
  logic [7:0] rom_code;
  logic [2:0] rom_row;

  glyph_row_fetch dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_icon(req_icon), .req_code(req_code), .req_row(req_row),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_data(pat_data),
    .rom_req_valid(rom_req_valid), .rom_code(rom_code), .rom_row(rom_row),
    .rom_data(rom_data), .wr_en(wr_en), .wr_icon(wr_icon),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [4:0] romf(input logic [7:0] c, input logic [2:0] r);
    return c[4:0] ^ {r, 2'b10};
  endfunction

  // Fixed-store model: answers one clock after a strobe, otherwise drifts.
  logic [4:0] rom_q = 5'd0;
  assign rom_data = rom_q;
  always @(posedge clk) begin
    if (rom_req_valid) rom_q <= romf(rom_code, rom_row);
    else               rom_q <= rom_q + 5'd7;
  end

  // Behavioural reference model.
  logic [4:0] pat_m [32];
  logic [4:0] icon_m [8];
  logic       m_v = 0;
  logic [4:0] m_d = 0;
  string      m_tag = "R2";
  always @(posedge clk) begin
    if (rst_n) begin
      if (req_valid && (!m_v || pat_ready)) begin
        m_v = 1;
        if (req_icon)           begin m_d = icon_m[req_row]; m_tag = "R5"; end
        else if (req_code < 4)  begin m_d = pat_m[{req_code[1:0], req_row}]; m_tag = "R2"; end
        else                    begin m_d = romf(req_code, req_row); m_tag = "R3"; end
      end else if (pat_ready) m_v = 0;
      if (wr_en) begin
        if (wr_icon) icon_m[wr_addr[2:0]] = wr_data;
        else         pat_m[wr_addr] = wr_data;
      end
    end else m_v = 0;
  end

  int total = 0, bad = 0;
  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic exp_rom;
    exp_rom = req_valid && (!m_v || pat_ready) && !req_icon && (req_code >= 4);
    chk("R8 req_ready", req_ready, !m_v || pat_ready);
    chk("R4 pat_valid", pat_valid, m_v);
    if (m_v) chk({m_tag, " R7 pat_data"}, pat_data, m_d);
    chk("R3 rom_req_valid", rom_req_valid, exp_rom);
    if (exp_rom) chk("R3 rom_code", {rom_row, rom_code}, {req_row, req_code});
  endtask

  task automatic idle();
    req_valid = 0; wr_en = 0; pat_ready = 1;
  endtask

  bit done = 0;
  initial begin
    idle();
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset valid", pat_valid, 0);
      chk("R1 reset ready", req_ready, 1);
    end
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {pat_valid, req_ready}, 2'b01);
    // R6: fill both RAMs; icon writes use dirty upper address bits.
    for (int i = 0; i < 40; i++) begin
      idle();
      wr_en = 1;
      wr_icon = (i >= 32);
      wr_addr = (i >= 32) ? 5'((i - 32) | 8'h18) : 5'(i);
      wr_data = 5'((i * 13 + 5) & 31);
      @(negedge clk); compare();
    end
    // Random traffic with back-pressure.
    for (int n = 0; n < 3000; n++) begin
      req_valid = ($urandom % 10) < 7;
      req_icon  = ($urandom % 5) == 0;
      req_code  = ($urandom % 2) ? 8'($urandom % 4) : 8'($urandom);
      req_row   = 3'($urandom);
      pat_ready = ($urandom % 10) < 7;
      wr_en     = ($urandom % 10) < 3;
      wr_icon   = $urandom % 2;
      wr_addr   = 5'($urandom);
      wr_data   = 5'($urandom);
      @(negedge clk); compare();
    end
    // R7 collisions: write the exact entry being read, then read it again.
    for (int n = 0; n < 200; n++) begin
      idle();
      req_valid = 1;
      req_icon  = n % 3 == 0;
      req_code  = 8'(n % 4);
      req_row   = 3'(n / 4);
      wr_en     = 1;
      wr_icon   = req_icon;
      wr_addr   = req_icon ? {2'b11, req_row} : {req_code[1:0], req_row};
      wr_data   = 5'($urandom);
      @(negedge clk); compare();
      wr_en = 0;
      @(negedge clk); compare();
    end
    idle();
    repeat (3) begin @(negedge clk); compare(); end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule